// File: doc/BRIEF.md
# Service Copy DMA with Alignment-Aware Bursts

This block is a single-channel copy engine. It reads a block of bytes from an external read port, which faces host memory, and writes the block into a local memory through a dword-wide write port. Software sets up a transfer through a small register file: an external source address, a local destination address, a byte count and a control word. The start bit in the control word launches the transfer. The byte count may be any non-zero value and does not have to be a multiple of four.

The engine divides the source range into read requests. A mode register selects the largest burst (64, 128 or 256 bytes) and, for 128-byte bursts, a split option. With split on, a burst longer than 64 bytes is issued only from a 128-byte-aligned address. A mode register field also caps how many read requests may be outstanding at once.

Read data comes back in request order, one dword per beat, and goes to consecutive local dword addresses. Byte enables trim the final partial dword. A read-only register shows how many bytes are still to be written. When the last write goes out, the start bit clears, busy falls and, if the control word asked for it, a one-cycle interrupt pulse is raised toward the host.

Top module: `svc_copy_dma`

## Requirements
- R1: After reset every register reads 0 (index 0 control, 1 source, 2 destination, 3 count, 4 bytes-left, 5 mode), busy and irq_host are 0, and no read request or local write is issued.
- R2: A control write with bit 31 set starts a transfer only if the source, destination and count registers have each been written since the last accepted start, the count is non-zero and the engine is idle; otherwise it is ignored and busy stays 0.
- R3: The mode register field [3:0] holds the outstanding-request limit; a written value above 12 is stored and read back as 12, and a value of 0 acts as a limit of 1.
- R4: The number of read requests accepted and not yet answered by a beat with rd_rsp_last never exceeds the limit; no request is offered while the limit is reached.
- R5: Mode field [9:8] selects the largest burst (0 gives 64, 1 gives 128, 2 gives 256, 3 gives 64 bytes); without split mode a request never crosses an address boundary of that size.
- R6: With mode bit 10 (split) set and 128-byte bursts selected, a request longer than 64 bytes starts only at a 128-byte-aligned address, and any other request does not cross a 64-byte boundary.
- R7: rd_req_len gives the request size in bytes; the last request is cut to the bytes not yet requested, and consecutive requests cover the source range without gap or overlap.
- R8: Each response beat is written one cycle later to the next local dword address, beginning at the destination address, with its data unchanged.
- R9: The write of the final dword of a byte count that is not a multiple of 4 carries wr_be set to 4'b0001, 4'b0011 or 4'b0111 for 1, 2 or 3 leftover bytes; all other writes carry 4'b1111.
- R10: Register 4 reads the number of bytes not yet written to the local port and decreases with every local write.
- R11: Busy and control readback bit 31 fall together with the final local write. On that same cycle irq_host pulses for one cycle if and only if control bits [25:24] held 2'b01 when the transfer started.
- R12: While busy, writes to the control and mode registers are ignored, and a request that is offered but not accepted keeps its address and length until it is accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_wr_en | input | 1 | Register write strobe |
| reg_idx | input | 3 | Register index for read and write |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data for reg_idx |
| rd_req_valid | output | 1 | Read request offered |
| rd_req_ready | input | 1 | Read request accepted |
| rd_req_addr | output | AW | External byte address of the request |
| rd_req_len | output | 9 | Request length in bytes |
| rd_rsp_valid | input | 1 | Read response beat (one dword) |
| rd_rsp_last | input | 1 | Final beat of the current response |
| rd_rsp_data | input | 32 | Response data |
| wr_valid | output | 1 | Local write strobe |
| wr_addr | output | AW | Local dword byte address |
| wr_data | output | 32 | Local write data |
| wr_be | output | 4 | Local write byte enables |
| irq_host | output | 1 | Completion pulse toward the host |
| busy | output | 1 | Transfer in progress |

## Verification
Busy rises on the clock edge that samples an accepted start. From the cycle after that edge, the first request is offered with its address and length visible on the same cycle. A request's state moves on at the edge where it is accepted. Each local write appears on the cycle after the response beat that carries its data, and the completion pulse and the fall of busy arrive together with the final write. The bench holds a behavioural model that steps on each rising edge with the same inputs. It compares every output between edges, at the falling edge, and reads registers through the register port at that same point.

// File: rtl/svc_dma_pkg.sv
package svc_dma_pkg;

    // Register indices on the register port
    typedef enum logic [2:0] {
        RG_CTRL  = 3'd0,
        RG_SRC   = 3'd1,
        RG_DST   = 3'd2,
        RG_COUNT = 3'd3,
        RG_LEFT  = 3'd4,
        RG_MODE  = 3'd5
    } reg_idx_e;

    localparam int unsigned LIM_W      = 4;
    localparam int unsigned MAX_BURST  = 256;
    localparam int unsigned LEN_W      = $clog2(MAX_BURST) + 1;

    // Control word fields
    localparam int unsigned CTRL_GO    = 31;
    localparam int unsigned CTRL_TGT   = 24;
    // Mode word fields
    localparam int unsigned MODE_SIZE  = 8;
    localparam int unsigned MODE_SPLIT = 10;

    localparam logic [1:0] TGT_HOST    = 2'b01;

    typedef struct packed {
        logic [LIM_W-1:0] lim;
        logic [1:0]       size;
        logic             split;
    } mode_t;

    // Byte enables for a dword holding n valid bytes (n = 1..4)
    function automatic logic [3:0] lane_mask(logic [2:0] n);
        case (n)
            3'd1:    return 4'b0001;
            3'd2:    return 4'b0011;
            3'd3:    return 4'b0111;
            default: return 4'b1111;
        endcase
    endfunction

endpackage

// File: rtl/svc_dma_regs.sv
module svc_dma_regs
    import svc_dma_pkg::*;
#(
    parameter int unsigned AW       = 32,
    parameter int unsigned CNT_W    = 16,
    parameter int unsigned MAX_PEND = 12
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [2:0]       idx,
    input  logic [31:0]      wdata,
    output logic [31:0]      rdata,
    input  logic             busy,
    input  logic [CNT_W-1:0] left,
    output logic             go,
    output logic [1:0]       go_tgt,
    output logic [AW-1:0]    src,
    output logic [AW-1:0]    dst,
    output logic [CNT_W-1:0] cnt,
    output mode_t            mode
);

    localparam logic [LIM_W-1:0] LIM_CAP = LIM_W'(MAX_PEND);

    typedef struct packed {
        logic [AW-1:0]    src;
        logic [AW-1:0]    dst;
        logic [CNT_W-1:0] cnt;
        logic [1:0]       tgt;
        mode_t            mode;
        logic [2:0]       seen;
    } regs_t;

    regs_t q, d;
    logic  go_d;

    always_comb begin
        d    = q;
        go_d = 1'b0;
        if (wr_en) begin
            case (reg_idx_e'(idx))
                RG_SRC: begin
                    d.src     = {wdata[AW-1:2], 2'b00};
                    d.seen[0] = 1'b1;
                end
                RG_DST: begin
                    d.dst     = {wdata[AW-1:2], 2'b00};
                    d.seen[1] = 1'b1;
                end
                RG_COUNT: begin
                    d.cnt     = wdata[CNT_W-1:0];
                    d.seen[2] = 1'b1;
                end
                RG_CTRL: begin
                    if (!busy) begin
                        d.tgt = wdata[CTRL_TGT+1:CTRL_TGT];
                        if (wdata[CTRL_GO] && (&q.seen) && (q.cnt != '0)) begin
                            go_d   = 1'b1;
                            d.seen = '0;
                        end
                    end
                end
                RG_MODE: begin
                    if (!busy) begin
                        d.mode.lim   = (wdata[LIM_W-1:0] > LIM_CAP) ? LIM_CAP
                                                                    : wdata[LIM_W-1:0];
                        d.mode.size  = wdata[MODE_SIZE+1:MODE_SIZE];
                        d.mode.split = wdata[MODE_SPLIT];
                    end
                end
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    always_comb begin
        case (reg_idx_e'(idx))
            RG_CTRL:  rdata = {busy, 5'b0, q.tgt, 24'b0};
            RG_SRC:   rdata = 32'(q.src);
            RG_DST:   rdata = 32'(q.dst);
            RG_COUNT: rdata = 32'(q.cnt);
            RG_LEFT:  rdata = 32'(left);
            RG_MODE:  rdata = {21'b0, q.mode.split, q.mode.size, 4'b0, q.mode.lim};
            default:  rdata = '0;
        endcase
    end

    assign go     = go_d;
    assign go_tgt = wdata[CTRL_TGT+1:CTRL_TGT];
    assign src    = q.src;
    assign dst    = q.dst;
    assign cnt    = q.cnt;
    assign mode   = q.mode;

    // R3: stored limit never exceeds the legal maximum
    p_lim_clamp_r3: assert property (@(posedge clk) disable iff (!rst_n)
        q.mode.lim <= LIM_CAP);

    // R2: an accepted start makes the engine busy on the next cycle
    p_start_busy_r2: assert property (@(posedge clk) disable iff (!rst_n)
        go |=> busy);

    // R12: mode is frozen while a transfer runs
    p_mode_frozen_r12: assert property (@(posedge clk) disable iff (!rst_n)
        busy |=> $stable(q.mode));

endmodule

// File: rtl/svc_dma_burst.sv
module svc_dma_burst
    import svc_dma_pkg::*;
#(
    parameter int unsigned CNT_W = 16
) (
    input  logic [7:0]       addr_lo,
    input  logic [CNT_W-1:0] left,
    input  logic [1:0]       size,
    input  logic             split,
    output logic [LEN_W-1:0] len
);

    logic [LEN_W-1:0] room;
    logic             cut64;

    // Split mode only narrows 128-byte bursts that start off a 128-byte line
    assign cut64 = split && (size == 2'd1) && (addr_lo[6:0] != 7'd0);

    always_comb begin
        if (cut64) begin
            room = LEN_W'(64) - LEN_W'(addr_lo[5:0]);
        end else begin
            case (size)
                2'd1:    room = LEN_W'(128) - LEN_W'(addr_lo[6:0]);
                2'd2:    room = LEN_W'(256) - LEN_W'(addr_lo);
                default: room = LEN_W'(64)  - LEN_W'(addr_lo[5:0]);
            endcase
        end
        len = (left < CNT_W'(room)) ? LEN_W'(left) : room;
    end

endmodule

// File: rtl/svc_dma_engine.sv
module svc_dma_engine
    import svc_dma_pkg::*;
#(
    parameter int unsigned AW       = 32,
    parameter int unsigned CNT_W    = 16,
    parameter int unsigned MAX_PEND = 12
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             go,
    input  logic [1:0]       go_tgt,
    input  logic [AW-1:0]    go_src,
    input  logic [AW-1:0]    go_dst,
    input  logic [CNT_W-1:0] go_cnt,
    input  logic [LIM_W-1:0] lim,
    input  logic [LEN_W-1:0] burst_len,
    output logic [AW-1:0]    req_addr,
    output logic [CNT_W-1:0] req_left,
    output logic             rd_req_valid,
    input  logic             rd_req_ready,
    input  logic             rd_rsp_valid,
    input  logic             rd_rsp_last,
    input  logic [31:0]      rd_rsp_data,
    output logic             wr_valid,
    output logic [AW-1:0]    wr_addr,
    output logic [31:0]      wr_data,
    output logic [3:0]       wr_be,
    output logic             irq,
    output logic             busy,
    output logic [CNT_W-1:0] left
);

    typedef struct packed {
        logic             act;
        logic [AW-1:0]    ra;
        logic [CNT_W-1:0] rl;
        logic [AW-1:0]    wnext;
        logic [CNT_W-1:0] wl;
        logic [LIM_W-1:0] pend;
        logic [1:0]       tgt;
        logic             wv;
        logic [AW-1:0]    wa;
        logic [31:0]      wd;
        logic [3:0]       be;
        logic             irq;
    } eng_t;

    eng_t             q, d;
    logic [LIM_W-1:0] eff_lim;
    logic             req_v;
    logic             fire;
    logic             rsp_end;
    logic [2:0]       step;

    always_comb begin
        eff_lim = (lim == '0) ? LIM_W'(1) : lim;
        req_v   = q.act && (q.rl != '0) && (q.pend < eff_lim);
        fire    = req_v && rd_req_ready;
        rsp_end = rd_rsp_valid && rd_rsp_last;
        step    = (q.wl >= CNT_W'(4)) ? 3'd4 : q.wl[2:0];

        d     = q;
        d.wv  = 1'b0;
        d.irq = 1'b0;

        if (go) begin
            d.act   = 1'b1;
            d.ra    = go_src;
            d.rl    = go_cnt;
            d.wnext = go_dst;
            d.wl    = go_cnt;
            d.tgt   = go_tgt;
            d.pend  = '0;
        end else begin
            if (fire) begin
                d.ra = q.ra + AW'(burst_len);
                d.rl = q.rl - CNT_W'(burst_len);
            end
            if (fire && !rsp_end)      d.pend = q.pend + LIM_W'(1);
            else if (!fire && rsp_end) d.pend = q.pend - LIM_W'(1);

            if (rd_rsp_valid && q.act) begin
                d.wv    = 1'b1;
                d.wa    = q.wnext;
                d.wd    = rd_rsp_data;
                d.be    = lane_mask(step);
                d.wnext = q.wnext + AW'(4);
                d.wl    = q.wl - CNT_W'(step);
                if (d.wl == '0) begin
                    d.act = 1'b0;
                    d.irq = (q.tgt == TGT_HOST);
                end
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign req_addr     = q.ra;
    assign req_left     = q.rl;
    assign rd_req_valid = req_v;
    assign wr_valid     = q.wv;
    assign wr_addr      = q.wa;
    assign wr_data      = q.wd;
    assign wr_be        = q.be;
    assign irq          = q.irq;
    assign busy         = q.act;
    assign left         = q.wl;

    // R4: outstanding requests stay within the legal maximum
    p_pend_cap_r4: assert property (@(posedge clk) disable iff (!rst_n)
        q.pend <= LIM_W'(MAX_PEND));

    // R12: an offered request holds until accepted
    p_req_hold_r12: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_req_valid && !rd_req_ready) |=>
            (rd_req_valid && $stable(q.ra) && $stable(burst_len)));

    // R11: completion interrupt is a single-cycle pulse
    p_irq_pulse_r11: assert property (@(posedge clk) disable iff (!rst_n)
        q.irq |=> !q.irq);

    // R11: activity ends only together with a local write
    p_done_write_r11: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(q.act) |-> q.wv);

    // R9: byte enables are contiguous from lane 0
    p_lane_r9: assert property (@(posedge clk) disable iff (!rst_n)
        q.wv |-> (q.be == 4'h1 || q.be == 4'h3 || q.be == 4'h7 || q.be == 4'hF));

    // R10: every local write lowers the bytes-left count
    p_left_drop_r10: assert property (@(posedge clk) disable iff (!rst_n)
        q.wv |-> (q.wl < $past(q.wl)));

endmodule

// File: rtl/svc_copy_dma.sv
module svc_copy_dma
    import svc_dma_pkg::*;
#(
    parameter int unsigned AW       = 32,
    parameter int unsigned CNT_W    = 16,
    parameter int unsigned MAX_PEND = 12
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             reg_wr_en,
    input  logic [2:0]       reg_idx,
    input  logic [31:0]      reg_wdata,
    output logic [31:0]      reg_rdata,
    output logic             rd_req_valid,
    input  logic             rd_req_ready,
    output logic [AW-1:0]    rd_req_addr,
    output logic [LEN_W-1:0] rd_req_len,
    input  logic             rd_rsp_valid,
    input  logic             rd_rsp_last,
    input  logic [31:0]      rd_rsp_data,
    output logic             wr_valid,
    output logic [AW-1:0]    wr_addr,
    output logic [31:0]      wr_data,
    output logic [3:0]       wr_be,
    output logic             irq_host,
    output logic             busy
);

    logic             go;
    logic [1:0]       go_tgt;
    logic [AW-1:0]    src, dst;
    logic [CNT_W-1:0] cnt, left, req_left;
    mode_t            mode;
    logic [LEN_W-1:0] blen;

    svc_dma_regs #(.AW(AW), .CNT_W(CNT_W), .MAX_PEND(MAX_PEND)) u_regs (
        .clk    (clk),
        .rst_n  (rst_n),
        .wr_en  (reg_wr_en),
        .idx    (reg_idx),
        .wdata  (reg_wdata),
        .rdata  (reg_rdata),
        .busy   (busy),
        .left   (left),
        .go     (go),
        .go_tgt (go_tgt),
        .src    (src),
        .dst    (dst),
        .cnt    (cnt),
        .mode   (mode)
    );

    svc_dma_burst #(.CNT_W(CNT_W)) u_burst (
        .addr_lo (rd_req_addr[7:0]),
        .left    (req_left),
        .size    (mode.size),
        .split   (mode.split),
        .len     (blen)
    );

    svc_dma_engine #(.AW(AW), .CNT_W(CNT_W), .MAX_PEND(MAX_PEND)) u_engine (
        .clk          (clk),
        .rst_n        (rst_n),
        .go           (go),
        .go_tgt       (go_tgt),
        .go_src       (src),
        .go_dst       (dst),
        .go_cnt       (cnt),
        .lim          (mode.lim),
        .burst_len    (blen),
        .req_addr     (rd_req_addr),
        .req_left     (req_left),
        .rd_req_valid (rd_req_valid),
        .rd_req_ready (rd_req_ready),
        .rd_rsp_valid (rd_rsp_valid),
        .rd_rsp_last  (rd_rsp_last),
        .rd_rsp_data  (rd_rsp_data),
        .wr_valid     (wr_valid),
        .wr_addr      (wr_addr),
        .wr_data      (wr_data),
        .wr_be        (wr_be),
        .irq          (irq_host),
        .busy         (busy),
        .left         (left)
    );

    assign rd_req_len = blen;

    // Boundary span used only by the checks below
    logic [9:0] span_chk;
    logic       split128;
    always_comb begin
        case (mode.size)
            2'd1:    span_chk = 10'd128;
            2'd2:    span_chk = 10'd256;
            default: span_chk = 10'd64;
        endcase
    end
    assign split128 = mode.split && (mode.size == 2'd1);

    // R5: without split a request stays inside one span
    p_no_cross_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_req_valid && !split128) |->
            ((10'(rd_req_addr[7:0]) & (span_chk - 10'd1)) + 10'(rd_req_len) <= span_chk));

    // R6: long bursts only from 128-byte-aligned addresses in split mode
    p_split_long_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_req_valid && split128 && rd_req_len > LEN_W'(64)) |->
            (rd_req_addr[6:0] == 7'd0));

    // R6: short bursts in split mode stay within a 64-byte line
    p_split_short_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_req_valid && split128 && rd_req_len <= LEN_W'(64)) |->
            (10'(rd_req_addr[5:0]) + 10'(rd_req_len) <= 10'd64));

    // R7: an offered request is never empty
    p_len_nz_r7: assert property (@(posedge clk) disable iff (!rst_n)
        rd_req_valid |-> (rd_req_len != '0));

endmodule

// File: tb/svc_copy_dma_tb.sv
module svc_copy_dma_tb;

    localparam int CLK_PERIOD = 10;
    localparam int WATCHDOG   = 150000;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_wr_en = 1'b0;
    logic [2:0]  reg_idx = '0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic        rd_req_valid;
    logic        rd_req_ready = 1'b0;
    logic [31:0] rd_req_addr;
    logic [8:0]  rd_req_len;
    logic        rd_rsp_valid = 1'b0;
    logic        rd_rsp_last = 1'b0;
    logic [31:0] rd_rsp_data = '0;
    logic        wr_valid;
    logic [31:0] wr_addr;
    logic [31:0] wr_data;
    logic [3:0]  wr_be;
    logic        irq_host;
    logic        busy;

    always #(CLK_PERIOD/2) clk = ~clk;

    svc_copy_dma u_dut (
        .clk(clk), .rst_n(rst_n),
        .reg_wr_en(reg_wr_en), .reg_idx(reg_idx), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .rd_req_valid(rd_req_valid), .rd_req_ready(rd_req_ready),
        .rd_req_addr(rd_req_addr), .rd_req_len(rd_req_len),
        .rd_rsp_valid(rd_rsp_valid), .rd_rsp_last(rd_rsp_last), .rd_rsp_data(rd_rsp_data),
        .wr_valid(wr_valid), .wr_addr(wr_addr), .wr_data(wr_data), .wr_be(wr_be),
        .irq_host(irq_host), .busy(busy)
    );

    int total = 0;
    int fails = 0;
    int cycles = 0;
    int irq_seen = 0;
    logic [3:0] last_be = '0;

    task automatic chk(bit ok, string req, string what, longint act, longint exp);
        total++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    // ---------------- behavioural reference model ----------------
    logic [31:0] m_src = 0, m_dst = 0;
    int          m_cnt = 0, m_lim = 0, m_size = 0;
    bit          m_split = 0;
    bit [2:0]    m_seen = 0;
    int          m_tgt = 0;
    bit          m_act = 0;
    logic [31:0] m_ra = 0, m_wan = 0, m_wa = 0, m_wd = 0;
    int          m_rl = 0, m_wl = 0, m_pend = 0;
    bit          m_wv = 0, m_irq = 0;
    int          m_be = 0;
    logic [31:0] qa[$];
    int          ql[$];
    int          rb = 0;
    logic [15:0] lfsr = 16'hACE1;

    function automatic int exp_len(logic [31:0] a, int remain, int sel, bit sp);
        int sz;
        int room;
        sz = (sel == 1) ? 128 : (sel == 2) ? 256 : 64;
        if (sp && sz == 128 && (a % 128) != 0) room = 64 - int'(a % 64);
        else                                   room = sz - int'(a % sz);
        return (remain < room) ? remain : room;
    endfunction

    function automatic logic [31:0] mem_at(logic [31:0] a);
        return {a[15:0] ^ 16'hC3A5, a[17:2]};
    endfunction

    function automatic bit exp_rv();
        int le;
        le = (m_lim == 0) ? 1 : m_lim;
        return m_act && m_rl > 0 && m_pend < le;
    endfunction

    always @(posedge clk) begin
        bit fire;
        bit old_act;
        int blen;
        int step;
        cycles++;
        lfsr <= {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
        if (!rst_n) begin
            m_src = 0; m_dst = 0; m_cnt = 0; m_lim = 0; m_size = 0; m_split = 0;
            m_seen = 0; m_tgt = 0; m_act = 0; m_rl = 0; m_wl = 0; m_pend = 0;
            m_wv = 0; m_irq = 0; qa.delete(); ql.delete(); rb = 0;
        end else begin
            old_act = m_act;
            fire = exp_rv() && rd_req_ready;
            blen = exp_len(m_ra, m_rl, m_size, m_split);
            m_wv = 0; m_irq = 0;
            if (fire) begin
                qa.push_back(m_ra); ql.push_back(blen);
                m_ra += blen; m_rl -= blen; m_pend++;
            end
            if (rd_rsp_valid) begin
                if (rd_rsp_last) begin
                    m_pend--; void'(qa.pop_front()); void'(ql.pop_front()); rb = 0;
                end else rb++;
                if (m_act) begin
                    step = (m_wl >= 4) ? 4 : m_wl;
                    m_wv = 1; m_wa = m_wan; m_wd = rd_rsp_data; m_be = (1 << step) - 1;
                    m_wan += 4; m_wl -= step;
                    if (m_wl == 0) begin m_act = 0; m_irq = (m_tgt == 1); end
                end
            end
            if (reg_wr_en) begin
                case (reg_idx)
                    3'd1: begin m_src = {reg_wdata[31:2], 2'b00}; m_seen[0] = 1; end
                    3'd2: begin m_dst = {reg_wdata[31:2], 2'b00}; m_seen[1] = 1; end
                    3'd3: begin m_cnt = int'(reg_wdata[15:0]); m_seen[2] = 1; end
                    3'd0: if (!old_act) begin
                        m_tgt = int'(reg_wdata[25:24]);
                        if (reg_wdata[31] && m_seen == 3'b111 && m_cnt != 0) begin
                            m_seen = 0; m_act = 1; m_ra = m_src; m_rl = m_cnt;
                            m_wan = m_dst; m_wl = m_cnt; m_pend = 0;
                        end
                    end
                    3'd5: if (!old_act) begin
                        m_lim = (reg_wdata[3:0] > 12) ? 12 : int'(reg_wdata[3:0]);
                        m_size = int'(reg_wdata[9:8]); m_split = reg_wdata[10];
                    end
                    default: ;
                endcase
            end
            if (cycles > WATCHDOG) begin
                fails++; total++;
                $display("FAIL R11 watchdog: transfer never completed (actual timeout, expected idle)");
                $display("%0d/%0d checks passed", total - fails, total);
                $finish;
            end
        end
    end

    // ---------------- stimulus for the read side ----------------
    always @(negedge clk) begin
        int nb;
        rd_req_ready = lfsr[2] | lfsr[5];
        if (!rst_n || qa.size() == 0 || !(lfsr[0] | lfsr[3])) begin
            rd_rsp_valid = 0; rd_rsp_last = 0;
        end else begin
            nb = (ql[0] + 3) / 4;
            rd_rsp_valid = 1;
            rd_rsp_data  = mem_at(qa[0] + 32'(4 * rb));
            rd_rsp_last  = (rb == nb - 1);
        end
    end

    // ---------------- per-cycle comparison ----------------
    always @(negedge clk) begin
        if (rst_n) begin
            chk(busy == m_act, "R11", "busy", busy, m_act);
            chk(irq_host == m_irq, "R11", "irq_host", irq_host, m_irq);
            chk(rd_req_valid == exp_rv(), "R4", "rd_req_valid", rd_req_valid, exp_rv());
            if (exp_rv()) begin
                chk(rd_req_addr == m_ra, "R7", "rd_req_addr", rd_req_addr, m_ra);
                chk(int'(rd_req_len) == exp_len(m_ra, m_rl, m_size, m_split),
                    "R5/R6", "rd_req_len", rd_req_len, exp_len(m_ra, m_rl, m_size, m_split));
            end
            chk(wr_valid == m_wv, "R8", "wr_valid", wr_valid, m_wv);
            if (m_wv) begin
                chk(wr_addr == m_wa, "R8", "wr_addr", wr_addr, m_wa);
                chk(wr_data == m_wd, "R8", "wr_data", wr_data, m_wd);
                chk(int'(wr_be) == m_be, "R9", "wr_be", wr_be, m_be);
            end
            if (wr_valid) last_be = wr_be;
            if (irq_host) irq_seen++;
        end
    end

    // ---------------- register access tasks ----------------
    task automatic wreg(int idx, logic [31:0] val);
        @(negedge clk);
        reg_wr_en = 1; reg_idx = 3'(idx); reg_wdata = val;
        @(negedge clk);
        reg_wr_en = 0;
    endtask

    task automatic rreg(int idx, output logic [31:0] val);
        @(negedge clk);
        reg_idx = 3'(idx);
        #1 val = reg_rdata;
    endtask

    task automatic wait_idle();
        for (int i = 0; i < 20000 && busy; i++) @(negedge clk);
    endtask

    task automatic setup(logic [31:0] s, logic [31:0] dd, int n);
        wreg(1, s); wreg(2, dd); wreg(3, 32'(n));
    endtask

    initial begin
        logic [31:0] v;
        int irq_before;
        repeat (5) @(negedge clk);
        rst_n = 1;

        // R1 reset state
        for (int i = 0; i < 6; i++) begin
            rreg(i, v);
            chk(v == 0, "R1", "reset register", v, 0);
        end
        chk(busy == 0 && irq_host == 0 && rd_req_valid == 0 && wr_valid == 0,
            "R1", "reset outputs", {busy, irq_host, rd_req_valid, wr_valid}, 0);

        // R2 start ignored: count never written
        wreg(1, 32'h100); wreg(2, 32'h0);
        wreg(0, 32'h8100_0000);
        repeat (3) @(negedge clk);
        chk(busy == 0, "R2", "start without count", busy, 0);
        // R2 start ignored: zero count
        wreg(3, 0);
        wreg(0, 32'h8100_0000);
        repeat (3) @(negedge clk);
        rreg(0, v);
        chk(busy == 0 && v[31] == 0, "R2", "start with zero count", v, 0);

        // R3 clamp of the limit
        wreg(5, 32'h0000_000F);
        rreg(5, v);
        chk(v[3:0] == 4'd12, "R3", "clamped limit", v[3:0], 12);

        // Transfer A: 64-byte bursts, limit 2, odd count, host interrupt
        wreg(5, 32'h0000_0002);
        setup(32'h0000_0124, 32'h0000_0040, 203);
        wreg(0, 32'h8100_0000);
        wait_idle();
        repeat (2) @(negedge clk);
        chk(irq_seen == 1, "R11", "irq pulses after A", irq_seen, 1);
        rreg(0, v);
        chk(v[31] == 0, "R11", "control bit 31 after A", v[31], 0);
        rreg(4, v);
        chk(v == 0, "R10", "bytes left after A", v, 0);

        // Transfer B: split mode, 128-byte bursts, limit 12
        wreg(5, 32'h0000_050C);
        setup(32'h0000_2040, 32'h0000_0800, 400);
        wreg(0, 32'h8100_0000);
        wait_idle();
        repeat (2) @(negedge clk);
        chk(irq_seen == 2, "R6", "B completed", irq_seen, 2);

        // Transfer C: 128-byte bursts without split
        wreg(5, 32'h0000_0104);
        setup(32'h0000_3020, 32'h0000_1000, 300);
        wreg(0, 32'h8100_0000);
        wait_idle();
        repeat (2) @(negedge clk);
        chk(irq_seen == 3, "R5", "C completed", irq_seen, 3);

        // Transfer D: 256-byte bursts, limit 0 acts as 1, no interrupt
        wreg(5, 32'h0000_0200);
        setup(32'h0000_4004, 32'h0000_2000, 1029);
        irq_before = irq_seen;
        wreg(0, 32'h8000_0000);
        repeat (30) @(negedge clk);
        rreg(4, v);
        chk(int'(v) == m_wl && v != 0, "R10", "bytes left mid transfer", v, m_wl);
        wreg(5, 32'h0000_03FF);
        rreg(5, v);
        chk(v == 32'h0000_0200, "R12", "mode write while busy", v, 32'h200);
        wreg(0, 32'h8100_0000);
        rreg(0, v);
        chk(v[25:24] == 2'b00, "R12", "control write while busy", v[25:24], 0);
        wait_idle();
        repeat (2) @(negedge clk);
        chk(irq_seen == irq_before, "R11", "no irq with target 0", irq_seen, irq_before);
        chk(busy == 0, "R3", "limit 0 transfer finished", busy, 0);

        // Transfer E: three bytes only, size code 3
        wreg(5, 32'h0000_0301);
        setup(32'h0000_5000, 32'h0000_3000, 3);
        wreg(0, 32'h8100_0000);
        wait_idle();
        repeat (2) @(negedge clk);
        chk(last_be == 4'b0111, "R9", "partial dword enables", last_be, 4'b0111);
        rreg(4, v);
        chk(v == 0, "R10", "bytes left after E", v, 0);

        $display("%0d/%0d checks passed", total - fails, total);
        $finish;
    end

endmodule